// File: doc/BRIEF.md
# Synchronous Burst Cache SRAM

This block is a behavioural, synthesizable model of a registered synchronous cache RAM. Each word is 18 bits wide and is split into two 9-bit byte lanes. The depth is set by an address-width parameter. Address, chip selects, write controls and strobes are all sampled on the rising clock edge. Read data leaves through an output register. The output drive flag is gated without a clock by an active-low output enable. Data uses separate `din` and `dout` buses, and `dout_en` stands in for a tristate driver.

A burst can be opened by either of two active-low strobes. One belongs to the processor and one to the cache controller. On the opening edge the upper address bits are stored and a 2-bit beat counter is cleared. Each later edge with the advance input low moves to the next word of the aligned 4-word block. The word order is interleaved or linear, chosen by `order_il`. Writes are self-timed. They are gated per lane by a global write, a byte-write enable and a per-lane select. A sleep input freezes the block and keeps its contents.

Top module: `burst_sram`

## Requirements
- R1: The device is selected only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. A strobe accepted while the device is not selected ends any burst. It reads nothing and writes nothing, so `dout_en` is 0 after that edge, and later advance cycles still read and write nothing.
- R2: `adsp_n`=0 is ignored while `ce1_n`=1, and that edge is handled as if the strobe were high. When both strobes are low, `adsp_n` wins. An edge opened by `adsp_n` is always a read, and the write inputs are ignored on it.
- R3: `adsc_n`=0 (with `adsp_n` not accepted) opens a burst at `addr`. Any write requested on that same edge goes to `addr`.
- R4: Data read at clock edge k is on `dout` after edge k, with `dout_en`=1. `dout_en` equals "read done on last edge" AND `oe_n`=0, and it follows `oe_n` with no clock edge.
- R5: With `order_il`=1, beat b of a burst that starts at offset s (`addr[1:0]`) reads offset s XOR b.
- R6: With `order_il`=0, beat b reads offset (s+b) mod 4. In both orders the bits above bit 1 never change within a burst.
- R7: While a burst is open and no strobe is accepted, the beat count goes up by one (mod 4) on an edge where `adv_n`=0. When `adv_n`=1, the same word is accessed again. Writes on such edges go to the word being accessed.
- R8: Lane 0 is bits 8:0 and lane 1 is bits 17:9. `gw_n`=0 writes both lanes. Otherwise, with `bwe_n`=0, lane i is written when `bw_n[i]`=0. Lanes that are not written keep their data. When no lane is written, the edge is a read.
- R9: While `sleep`=1, strobes, advance and writes are ignored. `dout_en` is 0 after each such edge, and memory contents and the burst position are kept for when sleep ends.
- R10: `rst_n`=0 closes any burst and clears the output flag. With no burst open and no strobe, edges read and write nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of burst state |
| addr | input | ADDR_W | Word address, captured on a strobe |
| ce1_n | input | 1 | Chip enable 1, active low; also qualifies the processor strobe |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3_n | input | 1 | Chip enable 3, active low |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | 2 | Per-lane write selects, active low |
| order_il | input | 1 | Burst order: 1 interleaved, 0 linear |
| oe_n | input | 1 | Output enable, active low, not clocked |
| sleep | input | 1 | Low-power freeze |
| din | input | 18 | Write data |
| dout | output | 18 | Registered read data |
| dout_en | output | 1 | Output drive flag |

## Verification
A wrong beat counter or a wrongly stored block address shows up on `dout` on the very next advancing edge, as a word from the wrong offset. The bench catches this because it sweeps every start offset in both orders over the whole array. Lane gating errors or stray writes, for example during sleep, on a deselected strobe, on a processor-strobe edge or after reset, stay hidden until the damaged word is read again. Each such case is therefore followed by targeted reads and by a full read-back of the array. Errors in the output flag show on `dout_en` one edge after the faulty access. A broken output-enable gate shows with no clock edge at all.

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  ce1_n,
  input  logic                  ce2,
  input  logic                  ce3_n,
  input  logic                  adsp_n,
  input  logic                  adsc_n,
  input  logic                  adv_n,
  input  logic                  gw_n,
  input  logic                  bwe_n,
  input  logic [1:0]            bw_n,
  input  logic                  order_il,
  input  logic                  oe_n,
  input  logic                  sleep,
  input  logic [2*LANE_W-1:0]   din,
  output logic [2*LANE_W-1:0]   dout,
  output logic                  dout_en
);
  localparam int WORD_W = 2 * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int HI_W   = ADDR_W - 2;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [HI_W-1:0]   hi_q;
  logic [1:0]        base_q, beat_q;
  logic              active_q, rd_q;
  logic [WORD_W-1:0] dout_q;

  function automatic logic [1:0] beat_off(input logic [1:0] s, input logic [1:0] b, input logic il);
    return il ? (s ^ b) : (s + b);
  endfunction

  wire sel   = !ce1_n && ce2 && !ce3_n;
  wire p_go  = !sleep && !adsp_n && !ce1_n;
  wire c_go  = !sleep && !p_go && !adsc_n;
  wire go    = p_go || c_go;
  wire cont  = !sleep && !go && active_q;

  wire [1:0]        beat_nx = beat_q + {1'b0, !adv_n};
  wire [1:0]        acc_off = beat_off(base_q, beat_nx, order_il);
  wire [ADDR_W-1:0] acc_a   = go ? addr : {hi_q, acc_off};
  wire              acc     = (go && sel) || cont;
  wire [1:0]        lane_we = {2{!gw_n}} | ({2{!bwe_n}} & ~bw_n);
  wire              wr      = acc && !p_go && (lane_we != 2'b00);

  always_ff @(posedge clk) begin
    for (int i = 0; i < 2; i++)
      if (wr && lane_we[i]) mem[acc_a][i*LANE_W +: LANE_W] <= din[i*LANE_W +: LANE_W];
    if (acc && !wr) dout_q <= mem[acc_a];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      rd_q     <= 1'b0;
      hi_q     <= '0;
      base_q   <= '0;
      beat_q   <= '0;
    end else if (sleep) begin
      rd_q <= 1'b0;
    end else begin
      rd_q <= acc && !wr;
      if (go) begin
        active_q <= sel;
        if (sel) begin
          hi_q   <= addr[ADDR_W-1:2];
          base_q <= addr[1:0];
          beat_q <= 2'd0;
        end
      end else if (cont) begin
        beat_q <= beat_nx;
      end
    end
  end

  assign dout    = dout_q;
  assign dout_en = rd_q && !oe_n;
endmodule

module burst_sram_chk #(
  parameter int HI_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ce1_n,
  input logic            ce2,
  input logic            ce3_n,
  input logic            adsp_n,
  input logic            adsc_n,
  input logic            adv_n,
  input logic            sleep,
  input logic            active_q,
  input logic            rd_q,
  input logic [1:0]      beat_q,
  input logic [HI_W-1:0] hi_q
);
  wire selected = !ce1_n && ce2 && !ce3_n;
  wire no_strb  = (adsp_n || ce1_n) && adsc_n;

  AST_DESEL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !adsp_n && !ce1_n && !selected) |=> (!rd_q && !active_q)); // R1
  AST_PSTART_READS: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !adsp_n && selected) |=> (rd_q && active_q && beat_q == 2'd0)); // R2
  AST_HOLD_NO_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && adv_n && no_strb && active_q) |=> $stable(beat_q)); // R7
  AST_ADV_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !adv_n && no_strb && active_q) |=> (beat_q == 2'($past(beat_q) + 2'd1))); // R7
  AST_SLEEP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> (!rd_q && $stable(beat_q) && $stable(hi_q) && $stable(active_q))); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !active_q && no_strb) |=> !rd_q); // R10
endmodule

bind burst_sram burst_sram_chk #(.HI_W(ADDR_W - 2)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
  .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n), .sleep(sleep),
  .active_q(active_q), .rd_q(rd_q), .beat_q(beat_q), .hi_q(hi_q)
);

// File: tb/test_burst_sram.sv
module test_burst_sram;
  localparam int AW = 6;
  localparam int N  = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr;
  logic ce1_n, ce2, ce3_n, adsp_n, adsc_n, adv_n, gw_n, bwe_n, order_il, oe_n, sleep;
  logic [1:0] bw_n;
  logic [17:0] din, dout;
  logic dout_en;

  logic [17:0] m [N];
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  burst_sram #(.ADDR_W(AW), .LANE_W(9)) i_burst_sram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n), .gw_n(gw_n), .bwe_n(bwe_n),
    .bw_n(bw_n), .order_il(order_il), .oe_n(oe_n), .sleep(sleep), .din(din),
    .dout(dout), .dout_en(dout_en));

  function automatic logic [17:0] pat(input int a, input int salt);
    return 18'((a * 3001 + salt * 977 + 17) ^ (a << 9));
  endfunction

  function automatic logic [1:0] off(input logic [1:0] s, input int b, input logic il);
    return il ? (s ^ 2'(b)) : 2'((int'(s) + b) % 4);
  endfunction

  task automatic idle();
    ce1_n = 0; ce2 = 1; ce3_n = 0; adsp_n = 1; adsc_n = 1; adv_n = 1;
    gw_n = 1; bwe_n = 1; bw_n = 2'b11; oe_n = 0; sleep = 0; din = '0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [18:0] act, input logic [18:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_rd(input string req, input logic [17:0] exp);
    chk(req, {dout_en, dout}, {1'b1, exp});
  endtask

  task automatic lane_wr(input int a, input logic [17:0] d, input logic g, input logic be, input logic [1:0] b);
    idle(); adsc_n = 0; addr = AW'(a); din = d; gw_n = g; bwe_n = be; bw_n = b;
    tick();
    if (!g || (!be && !b[0])) m[a][8:0]  = d[8:0];
    if (!g || (!be && !b[1])) m[a][17:9] = d[17:9];
    idle();
  endtask

  task automatic p_read(input int a, input string req);
    idle(); adsp_n = 0; addr = AW'(a);
    tick(); chk_rd(req, m[a]); idle();
  endtask

  initial begin
    idle(); addr = '0; order_il = 0;
    tick(); tick();
    chk("R10 reset flag", {dout_en, 18'h0}, 19'h0);
    rst_n = 1; tick();

    for (int a = 0; a < N; a++) lane_wr(a, pat(a, 0), 1'b0, 1'b1, 2'b11);
    chk("R10 write leaves flag low", {dout_en, 18'h0}, 19'h0);

    // R5 / R6: every start offset, both orders, one extra beat to show wrap
    for (int il = 0; il < 2; il++)
      for (int a = 0; a < N; a++) begin
        idle(); order_il = il[0]; adsp_n = 0; addr = AW'(a);
        tick(); chk(il ? "R5 first beat" : "R6 first beat", {dout_en, dout}, {1'b1, m[a]});
        idle(); adv_n = 0;
        for (int b = 1; b <= 4; b++) begin
          tick();
          chk(il ? "R5 interleaved beat" : "R6 linear beat", {dout_en, dout},
              {1'b1, m[{a[AW-1:2], off(a[1:0], b % 4, il[0])}]});
        end
      end
    order_il = 0;

    // R7: hold without advance
    idle(); adsp_n = 0; addr = 6'd13; tick(); idle();
    tick(); chk_rd("R7 hold", m[13]);
    adv_n = 0; tick(); chk_rd("R7 step", m[14]);
    adv_n = 1; tick(); chk_rd("R7 hold again", m[14]);

    // R8: lane gating
    for (int a = 0; a < 8; a++) lane_wr(16 + a, pat(a, 5), 1'b1, 1'b0, 2'(a));
    lane_wr(24, pat(24, 6), 1'b0, 1'b0, 2'b11);
    for (int a = 16; a < 25; a++) p_read(a, "R8 lane result");
    idle(); adsc_n = 0; addr = 6'd25; din = pat(1, 9); tick();
    chk_rd("R8 no lane is read", m[25]);

    // R3 / R7: write on advancing beat
    idle(); adsc_n = 0; addr = 6'd10; tick(); chk_rd("R3 controller start", m[10]);
    idle(); adv_n = 0; gw_n = 0; din = pat(11, 7); tick(); m[11] = pat(11, 7);
    chk("R8 write cycle flag", {dout_en, 18'h0}, 19'h0);
    idle(); adv_n = 0; tick(); chk_rd("R7 wrap after write", m[8]);
    p_read(11, "R3 advanced write");

    // R1: deselect
    idle(); adsc_n = 0; ce2 = 0; gw_n = 0; addr = 6'd20; din = 18'h3ffff; tick();
    chk("R1 deselect flag", {dout_en, 18'h0}, 19'h0);
    idle(); adv_n = 0; gw_n = 0; din = 18'h2aaaa; tick();
    chk("R1 idle after deselect", {dout_en, 18'h0}, 19'h0);
    idle(); adsp_n = 0; ce3_n = 1; addr = 6'd21; tick();
    chk("R1 ce3 deselect", {dout_en, 18'h0}, 19'h0);
    p_read(20, "R1 no write");
    p_read(21, "R1 no write next");

    // R2: processor strobe ignored with ce1_n high, and priority
    idle(); order_il = 1; adsp_n = 0; addr = 6'd32; tick(); chk_rd("R2 start", m[32]);
    idle(); ce1_n = 1; adsp_n = 0; adv_n = 0; addr = 6'd44; tick();
    chk_rd("R2 ignored strobe advances", m[33]);
    order_il = 0;
    idle(); adsp_n = 0; adsc_n = 0; gw_n = 0; addr = 6'd40; din = 18'h15555; tick();
    chk_rd("R2 priority read", m[40]);
    p_read(40, "R2 no write");

    // R4: asynchronous output enable
    oe_n = 1; #1; chk("R4 oe high", {dout_en, 18'h0}, 19'h0);
    oe_n = 0; #1; chk_rd("R4 oe low", m[40]);

    // R9: sleep
    idle(); adsp_n = 0; addr = 6'd49; tick(); chk_rd("R9 pre", m[49]);
    idle(); sleep = 1; adv_n = 0; adsc_n = 0; gw_n = 0; addr = 6'd5; din = 18'h0f0f0; tick();
    chk("R9 sleep flag", {dout_en, 18'h0}, 19'h0);
    tick();
    idle(); adv_n = 0; tick(); chk_rd("R9 resume position", m[50]);
    p_read(5, "R9 no write");

    // R10: reset mid burst
    idle(); adsp_n = 0; addr = 6'd56; tick();
    rst_n = 0; tick(); rst_n = 1;
    idle(); adv_n = 0; gw_n = 0; din = 18'h3c3c3; tick();
    chk("R10 closed burst", {dout_en, 18'h0}, 19'h0);

    for (int a = 0; a < N; a++) p_read(a, "R8 final array");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule